// File: doc/BRIEF.md
# Sound Interrupt Controller for Two Processors

This block collects interrupt requests from a sound subsystem and presents them to two processors: a slave audio processor and a main host processor. Each processor has its own enable, pending and clear registers. All of them are reached through one simple register port. That port has a write strobe, an address, write data and a combinational read bus. The request sources are three timer overflow events, a sample-done event and a software request. Software raises its request by writing into a pending register.

For the slave processor, the block picks the lowest-numbered source that is both enabled and pending. It then forms a 3-bit interrupt level for that source. Bit k of the level is looked up in level-select table k, indexed by the source number. Sources numbered above 7 all use table entry 7. The slave outputs are combinational from the register state. For the host processor, a two-state machine drives one level-sensitive interrupt line. The machine has two states. HOST_QUIET moves to HOST_RAISED on the transition "any host source active". HOST_RAISED moves back to HOST_QUIET on the transition "no host source active". The line is high exactly in HOST_RAISED, so it follows the host active set with one clock of delay.

Top module: `snd_irq_ctrl`

## Requirements
- R1: A source is active on a side only when its bit is 1 in both that side's enable and pending registers. `slv_irq_vld` is high exactly when some slave source is active. When no slave source is active, `slv_irq_lvl` is 0.
- R2: When several slave sources are active, the lowest-numbered active source sets the level.
- R3: Bit k (k = 0, 1, 2) of `slv_irq_lvl` is entry s of level table k, where s is the winning source number.
- R4: A winning source numbered 8 or higher uses entry 7 of each level table.
- R5: A write to a pending register with data bit 5 set makes that side's pending bit 5 (software request) 1. The other data bits of that write have no effect.
- R6: A write to a clear register makes 0 every pending bit of that side whose data bit is 1. A read of a clear register returns 0.
- R7: `host_irq` is high in the cycle after any host source is active. It is low in the cycle after no host source is active.
- R8: Pending bits 6, 7 and 8 are set on both sides by the timer A, B and C events. Bit 10 is set by the sample-done event, on the slave side only.
- R9: When a request event and a clear write hit the same pending bit in the same cycle, the bit ends at 1.
- R10: After reset, all registers read 0, `slv_irq_vld` is 0, `slv_irq_lvl` is 0 and `host_irq` is 0.
- R11: Register addresses:
  - 0: slave enable
  - 1: slave pending
  - 2: slave clear
  - 3: host enable
  - 4: host pending
  - 5: host clear
  - 6, 7, 8: level tables 0, 1, 2 (8 bits each, bit i is entry i)
  - Register bit n is source n.
  - Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Combinational read data at `addr` |
| tmr_a_evt | input | 1 | Timer A overflow event |
| tmr_b_evt | input | 1 | Timer B overflow event |
| tmr_c_evt | input | 1 | Timer C overflow event |
| smp_done_evt | input | 1 | Sample-done event |
| slv_irq_vld | output | 1 | Slave interrupt request present |
| slv_irq_lvl | output | 3 | Slave interrupt level |
| host_irq | output | 1 | Host interrupt line |

## Verification
The assertions check the following on every cycle:
- the zero level while no slave request is valid;
- the one-cycle lag of the host line behind its active set;
- the zero read-back of the clear registers;
- the software-request set;
- a timer event reaching both sides;
- a timer event winning over a clear in the same cycle.

Only the bench scenarios can show the rest. These are the priority order among several active sources, the level lookup and the clamp to entry 7, and the fact that ignored pending-write bits and the host-side absence of sample-done leave the registers unchanged.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SIC_AW = 4;

    localparam logic [SIC_AW-1:0] A_SLV_EN  = 4'd0;
    localparam logic [SIC_AW-1:0] A_SLV_PND = 4'd1;
    localparam logic [SIC_AW-1:0] A_SLV_CLR = 4'd2;
    localparam logic [SIC_AW-1:0] A_HST_EN  = 4'd3;
    localparam logic [SIC_AW-1:0] A_HST_PND = 4'd4;
    localparam logic [SIC_AW-1:0] A_HST_CLR = 4'd5;
    localparam logic [SIC_AW-1:0] A_LVL0    = 4'd6;

    localparam int B_SW  = 5;
    localparam int B_TMA = 6;
    localparam int B_TMB = 7;
    localparam int B_TMC = 8;
    localparam int B_SMP = 10;

    typedef enum logic {
        HOST_QUIET  = 1'b0,
        HOST_RAISED = 1'b1
    } host_st_e;
endpackage

// File: rtl/sic_pend_bank.sv
module sic_pend_bank #(
    parameter int NUM_SRC = 11,
    parameter int SW_BIT  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic               pnd_we,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] active
);
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] pend_nxt;

    always_comb begin
        clr_mask = clr_we ? wdata : '0;
        sw_set   = '0;
        sw_set[SW_BIT] = pnd_we & wdata[SW_BIT];
        // set sources applied after the clear so a same-cycle event wins
        pend_nxt = (pending & ~clr_mask) | evt | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable  <= '0;
            pending <= '0;
        end else begin
            if (en_we) enable <= wdata;
            pending <= pend_nxt;
        end
    end

    assign active = enable & pending;
endmodule

// File: rtl/sic_prio_lvl.sv
module sic_prio_lvl #(
    parameter int NUM_SRC     = 11,
    parameter int LVL_BITS    = 3,
    parameter int LVL_ENTRIES = 8
) (
    input  logic [NUM_SRC-1:0]                     active,
    input  logic [LVL_BITS-1:0][LVL_ENTRIES-1:0]   lvl_tab,
    output logic                                   valid,
    output logic [LVL_BITS-1:0]                    level
);
    localparam int EW = (LVL_ENTRIES > 1) ? $clog2(LVL_ENTRIES) : 1;

    int unsigned win;
    logic [EW-1:0] eidx;

    always_comb begin
        valid = 1'b0;
        win   = 0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!valid && active[i]) begin
                valid = 1'b1;
                win   = i;
            end
        end
        if (win > LVL_ENTRIES - 1) eidx = EW'(LVL_ENTRIES - 1);
        else                       eidx = EW'(win);
    end

    for (genvar b = 0; b < LVL_BITS; b++) begin : g_lvl
        assign level[b] = valid & lvl_tab[b][eidx];
    end
endmodule

// File: rtl/sic_host_fsm.sv
module sic_host_fsm
    import sic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_act,
    output logic irq
);
    host_st_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HOST_QUIET;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        irq       = 1'b0;
        unique case (state)
            HOST_QUIET: begin
                if (any_act) state_nxt = HOST_RAISED;
            end
            HOST_RAISED: begin
                irq = 1'b1;
                if (!any_act) state_nxt = HOST_QUIET;
            end
            default: state_nxt = HOST_QUIET;
        endcase
    end
endmodule

// File: rtl/snd_irq_ctrl.sv
module snd_irq_ctrl
    import sic_pkg::*;
#(
    parameter int NUM_SRC     = 11,
    parameter int REG_W       = 16,
    parameter int LVL_BITS    = 3,
    parameter int LVL_ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SIC_AW-1:0]   addr,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                tmr_a_evt,
    input  logic                tmr_b_evt,
    input  logic                tmr_c_evt,
    input  logic                smp_done_evt,
    output logic                slv_irq_vld,
    output logic [LVL_BITS-1:0] slv_irq_lvl,
    output logic                host_irq
);
    logic [NUM_SRC-1:0] wd_src;
    logic               unused_hi;
    assign wd_src    = wr_data[NUM_SRC-1:0];
    assign unused_hi = ^wr_data[REG_W-1:NUM_SRC];

    logic [NUM_SRC-1:0] slv_evt, hst_evt;
    always_comb begin
        hst_evt        = '0;
        hst_evt[B_TMA] = tmr_a_evt;
        hst_evt[B_TMB] = tmr_b_evt;
        hst_evt[B_TMC] = tmr_c_evt;
        slv_evt        = hst_evt;
        slv_evt[B_SMP] = smp_done_evt;
    end

    logic [NUM_SRC-1:0] slv_en, slv_pend, slv_act;
    logic [NUM_SRC-1:0] hst_en, hst_pend, hst_act;

    sic_pend_bank #(.NUM_SRC(NUM_SRC), .SW_BIT(B_SW)) u_slv_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (wr_en && addr == A_SLV_EN),
        .pnd_we  (wr_en && addr == A_SLV_PND),
        .clr_we  (wr_en && addr == A_SLV_CLR),
        .wdata   (wd_src),
        .evt     (slv_evt),
        .enable  (slv_en),
        .pending (slv_pend),
        .active  (slv_act)
    );

    sic_pend_bank #(.NUM_SRC(NUM_SRC), .SW_BIT(B_SW)) u_hst_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (wr_en && addr == A_HST_EN),
        .pnd_we  (wr_en && addr == A_HST_PND),
        .clr_we  (wr_en && addr == A_HST_CLR),
        .wdata   (wd_src),
        .evt     (hst_evt),
        .enable  (hst_en),
        .pending (hst_pend),
        .active  (hst_act)
    );

    logic [LVL_BITS-1:0][LVL_ENTRIES-1:0] lvl_tab;

    for (genvar g = 0; g < LVL_BITS; g++) begin : g_tab
        localparam logic [SIC_AW-1:0] TAB_ADDR = A_LVL0 + SIC_AW'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           lvl_tab[g] <= '0;
            else if (wr_en && addr == TAB_ADDR)   lvl_tab[g] <= wr_data[LVL_ENTRIES-1:0];
        end
    end

    sic_prio_lvl #(
        .NUM_SRC(NUM_SRC), .LVL_BITS(LVL_BITS), .LVL_ENTRIES(LVL_ENTRIES)
    ) u_prio (
        .active  (slv_act),
        .lvl_tab (lvl_tab),
        .valid   (slv_irq_vld),
        .level   (slv_irq_lvl)
    );

    sic_host_fsm u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_act (|hst_act),
        .irq     (host_irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            A_SLV_EN:  rd_data = REG_W'(slv_en);
            A_SLV_PND: rd_data = REG_W'(slv_pend);
            A_HST_EN:  rd_data = REG_W'(hst_en);
            A_HST_PND: rd_data = REG_W'(hst_pend);
            default: begin
                for (int t = 0; t < LVL_BITS; t++) begin
                    if (addr == A_LVL0 + SIC_AW'(t)) rd_data = REG_W'(lvl_tab[t]);
                end
            end
        endcase
    end
endmodule

// File: rtl/sic_chk.sv
module sic_chk
    import sic_pkg::*;
#(
    parameter int NUM_SRC  = 11,
    parameter int REG_W    = 16,
    parameter int LVL_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [SIC_AW-1:0]   addr,
    input logic [REG_W-1:0]    wr_data,
    input logic [REG_W-1:0]    rd_data,
    input logic                tmr_a_evt,
    input logic                tmr_b_evt,
    input logic                slv_irq_vld,
    input logic [LVL_BITS-1:0] slv_irq_lvl,
    input logic                host_irq,
    input logic [NUM_SRC-1:0]  slv_act,
    input logic [NUM_SRC-1:0]  slv_pend,
    input logic [NUM_SRC-1:0]  hst_pend,
    input logic [NUM_SRC-1:0]  hst_act
);
    AST_IDLE_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !slv_irq_vld |-> slv_irq_lvl == '0); // R1
    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n) slv_irq_vld == (|slv_act)); // R1
    AST_HOST_RISE: assert property (@(posedge clk) disable iff (!rst_n) (|hst_act) |=> host_irq); // R7
    AST_HOST_FALL: assert property (@(posedge clk) disable iff (!rst_n) !(|hst_act) |=> !host_irq); // R7
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (addr == A_SLV_CLR || addr == A_HST_CLR) |-> rd_data == '0); // R6
    AST_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == A_SLV_PND && wr_data[B_SW]) |=> slv_pend[B_SW]); // R5
    AST_TMR_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n) tmr_a_evt |=> (slv_pend[B_TMA] && hst_pend[B_TMA])); // R8
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n) (tmr_b_evt && wr_en && addr == A_SLV_CLR) |=> slv_pend[B_TMB]); // R9
endmodule

bind snd_irq_ctrl sic_chk #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .LVL_BITS(LVL_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .tmr_a_evt   (tmr_a_evt),
    .tmr_b_evt   (tmr_b_evt),
    .slv_irq_vld (slv_irq_vld),
    .slv_irq_lvl (slv_irq_lvl),
    .host_irq    (host_irq),
    .slv_act     (slv_act),
    .slv_pend    (slv_pend),
    .hst_pend    (hst_pend),
    .hst_act     (hst_act)
);

// File: tb/snd_irq_ctrl_tb.sv
`timescale 1ns/1ps
module snd_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic        tmr_a_evt = 1'b0, tmr_b_evt = 1'b0, tmr_c_evt = 1'b0, smp_done_evt = 1'b0;
    logic [15:0] rd_data;
    logic        slv_irq_vld, host_irq;
    logic [2:0]  slv_irq_lvl;

    int errs = 0;
    int nchk = 0;
    bit done = 0;

    logic [10:0] m_sen = '0, m_spd = '0, m_hen = '0, m_hpd = '0;
    logic [7:0]  m_lv [3] = '{8'h0, 8'h0, 8'h0};
    logic        m_host = 1'b0;

    always #2.5 clk = ~clk;

    snd_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tmr_a_evt(tmr_a_evt), .tmr_b_evt(tmr_b_evt),
        .tmr_c_evt(tmr_c_evt), .smp_done_evt(smp_done_evt),
        .slv_irq_vld(slv_irq_vld), .slv_irq_lvl(slv_irq_lvl), .host_irq(host_irq)
    );

    function automatic logic [3:0] exp_slave();
        for (int i = 0; i < 11; i++) begin
            if (m_sen[i] && m_spd[i]) begin
                automatic int e = (i > 7) ? 7 : i;
                return {1'b1, m_lv[2][e], m_lv[1][e], m_lv[0][e]};
            end
        end
        return 4'b0000;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return {5'b0, m_sen};
            4'd1: return {5'b0, m_spd};
            4'd3: return {5'b0, m_hen};
            4'd4: return {5'b0, m_hpd};
            4'd6: return {8'b0, m_lv[0]};
            4'd7: return {8'b0, m_lv[1]};
            4'd8: return {8'b0, m_lv[2]};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag);
        check({tag, " slave vld/lvl (R1 R2 R3 R4)"}, {12'b0, slv_irq_vld, slv_irq_lvl}, {12'b0, exp_slave()});
        check({tag, " host line R7"}, {15'b0, host_irq}, {15'b0, m_host});
    endtask

    task automatic step(input logic wen, input logic [3:0] a, input logic [15:0] d,
                        input logic ta, input logic tb, input logic tc, input logic sd,
                        input string tag);
        @(negedge clk);
        wr_en = wen; addr = a; wr_data = d;
        tmr_a_evt = ta; tmr_b_evt = tb; tmr_c_evt = tc; smp_done_evt = sd;
        @(posedge clk);
        m_host = |(m_hen & m_hpd);
        if (wen) begin
            case (a)
                4'd0: m_sen = d[10:0];
                4'd1: if (d[5]) m_spd[5] = 1'b1;
                4'd2: m_spd = m_spd & ~d[10:0];
                4'd3: m_hen = d[10:0];
                4'd4: if (d[5]) m_hpd[5] = 1'b1;
                4'd5: m_hpd = m_hpd & ~d[10:0];
                4'd6: m_lv[0] = d[7:0];
                4'd7: m_lv[1] = d[7:0];
                4'd8: m_lv[2] = d[7:0];
                default: ;
            endcase
        end
        m_spd = m_spd | {sd, 1'b0, tc, tb, ta, 6'b0};
        m_hpd = m_hpd | {2'b0, tc, tb, ta, 6'b0};
        #1;
        wr_en = 1'b0; tmr_a_evt = 1'b0; tmr_b_evt = 1'b0; tmr_c_evt = 1'b0; smp_done_evt = 1'b0;
        chk_out(tag);
    endtask

    task automatic chk_rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        check(tag, rd_data, exp_read(a));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errs++; nchk++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10 reset state
        chk_out("R10 reset");
        for (int a = 0; a < 9; a++) chk_rd(4'(a), "R10 reset readback");

        // level tables and enables (R11 map)
        step(1, 4'd6, 16'h00A5, 0,0,0,0, "R11 lvl0");
        step(1, 4'd7, 16'h00C3, 0,0,0,0, "R11 lvl1");
        step(1, 4'd8, 16'h0096, 0,0,0,0, "R11 lvl2");
        step(1, 4'd0, 16'h07FF, 0,0,0,0, "R11 slave enable");
        step(1, 4'd3, 16'h07FF, 0,0,0,0, "R11 host enable");

        // R5 software request, other bits ignored
        step(1, 4'd1, 16'hFFFF, 0,0,0,0, "R5 sw raise R3");
        chk_rd(4'd1, "R5 slave pending only bit5");
        step(0, 4'd0, 16'h0, 0,0,0,0, "R5 settle");
        // R6 clear and clear reads zero
        step(1, 4'd2, 16'h0020, 0,0,0,0, "R6 clear sw");
        chk_rd(4'd1, "R6 pending cleared");
        chk_rd(4'd2, "R6 clear reg reads zero");
        step(1, 4'd1, 16'hFFDF, 0,0,0,0, "R5 no bit5 no effect");
        chk_rd(4'd1, "R5 pending unchanged");

        // R8 R4 timer C goes to both sides, uses entry 7
        step(0, 4'd0, 16'h0, 0,0,1,0, "R8 R4 timer C");
        step(0, 4'd0, 16'h0, 0,0,0,0, "R7 host rises");
        chk_rd(4'd4, "R8 host pending timer C");
        // R8 sample done slave only
        step(0, 4'd0, 16'h0, 0,0,0,1, "R8 sample done");
        chk_rd(4'd4, "R8 host lacks sample bit");
        chk_rd(4'd1, "R8 slave has sample bit");
        // R2 timer A outranks C
        step(0, 4'd0, 16'h0, 1,0,0,0, "R2 timer A wins");
        // R9 event versus same-cycle clear
        step(1, 4'd2, 16'h07FF, 0,1,0,0, "R9 event beats clear");
        chk_rd(4'd1, "R9 bit7 survives");
        step(1, 4'd5, 16'h07FF, 0,0,0,0, "R6 host clear all");
        step(0, 4'd0, 16'h0, 0,0,0,0, "R7 host falls");
        // R1 disabled source gives no request
        step(1, 4'd0, 16'h0000, 0,0,0,0, "R1 all disabled");
        step(1, 4'd0, 16'h0400, 0,0,0,0, "R1 R4 only bit10 enabled");

        for (int n = 0; n < 500; n++) begin
            automatic logic wen = ($urandom % 3) == 0;
            automatic logic [3:0] a = 4'($urandom % 10);
            automatic logic [15:0] d = 16'($urandom);
            step(wen, a, d, ($urandom % 6) == 0, ($urandom % 6) == 0,
                 ($urandom % 6) == 0, ($urandom % 6) == 0, "random R1 R2 R3 R7");
            if ((n % 7) == 0) chk_rd(4'($urandom % 10), "random readback R5 R6 R8 R9");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule